// File: doc/BRIEF.md
# Extended-Arithmetic and Shift Flag Unit

This block produces the 32-bit result and the five condition flags (extend, negative, zero, overflow, carry) for extended add and subtract, the three shift kinds, and compare. It also rebuilds flags from a saved result and source operand for plain add, subtract and logic operations, packs the flags into a status byte, and loads them back from an operand. An integer pipeline feeds it two operands, an operation code, a shift count and the current flags. It returns the new result and flags one clock after `valid_i`.

Flags travel as a 5-bit vector ordered {X, N, Z, V, C}, with X in bit 4 and C in bit 0, on both `flags_i` and `flags_o`. The result register and the flag register load only when `valid_i` is high.

Top module: `xflag_unit`

## Requirements
- R1: After reset `res_o` and `flags_o` are zero. They are loaded one cycle after a cycle with `valid_i` high, and they hold their values while `valid_i` is low.
- R2: Op 4'h0 (add-extend) gives res = a + b + X. The carry is (res <= b) when X=1 and (res < b) when X=0, and it is written to both C and X.
- R3: Op 4'h1 (subtract-extend) gives res = a - b - X. The borrow is (a <= b) when X=1 and (a < b) when X=0, and it is written to both C and X.
- R4: For ops 4'h0 and 4'h1, Z can only be cleared. A nonzero result clears Z. A zero result leaves Z as it came in.
- R5: N is bit 31 of the result. Add overflow is bit 31 of (res^a)&~(a^b). Subtract overflow is bit 31 of (res^a)&(a^b).
- R6: Op 4'h2 (shift left) uses the count modulo 64. Its result is zero for counts of 32 or more, and C is the last bit shifted out past bit 31.
- R7: Op 4'h3 (logical right) and op 4'h4 (arithmetic right) take C from the last bit shifted out below bit 0. Op 4'h4 fills with the sign bit and gives all sign bits for counts of 32 or more. For shifts N is bit 31 of the result, Z is set when the result is zero, and V is 0.
- R8: For every shift op, X takes the new C only when the count modulo 64 is nonzero. A zero count passes the operand through unchanged, clears C and keeps X.
- R9: Op 4'h5 (compare) outputs a - b. N and Z come from that difference, C is the unsigned a < b, V follows the subtract rule, and X is kept.
- R10: Op 4'h8 (logic) outputs a. N and Z come from a, C and V are cleared, and X is kept.
- R11: Op 4'h6 (rebuild add) and op 4'h7 (rebuild subtract) treat a as the saved result and b as the second source. They recover the first source as a-b or a+b, apply the R5 overflow rule, take C from the incoming X, and keep X. The output is a.
- R12: Op 4'h9 (pack) outputs the flags zero-extended as {X,N,Z,V,C} in bits 4..0. The flags stay unchanged.
- R13: Op 4'hA (load flags) sets the flags from a[4:0] and outputs a & 0x1F. Op 4'hB (status write) also sets the flags from a[4:0] but outputs a & 0x0000FFE0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First operand or saved result |
| b_i | input | 32 | Second operand |
| shamt_i | input | 8 | Shift count, used modulo 64 |
| flags_i | input | 5 | Current flags {X,N,Z,V,C} |
| res_o | output | 32 | Registered result |
| flags_o | output | 5 | Registered flags {X,N,Z,V,C} |

## Verification
The bench targets the carry and borrow edges where X=1 turns a strict compare into a non-strict one. A design that ignores X there misses the carry when a+b+1 wraps to exactly b. It also drives zero results into extended ops with Z both set and clear: a non-sticky Z would set a flag that must stay clear.

Shift counts of 0, 32, 33, 40, 64 and 65 expose several faults:
- a count that is not wrapped modulo 64;
- a lost carry at the 32-bit boundary;
- a missing sign fill;
- an X that moves on a zero count.

Compare and rebuild ops are run at the signed-overflow boundary to catch a swapped overflow rule.

// File: rtl/xflag_pkg.sv
package xflag_pkg;
  typedef enum logic [3:0] {
    OP_ADDX  = 4'h0,
    OP_SUBX  = 4'h1,
    OP_LSL   = 4'h2,
    OP_LSR   = 4'h3,
    OP_ASR   = 4'h4,
    OP_CMP   = 4'h5,
    OP_RADD  = 4'h6,
    OP_RSUB  = 4'h7,
    OP_LOGIC = 4'h8,
    OP_PACK  = 4'h9,
    OP_LDCCR = 4'hA,
    OP_LDSR  = 4'hB
  } op_e;

  typedef struct packed {
    logic x;
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  localparam int unsigned FLAG_W = 5;
  localparam logic [15:0] SR_KEEP = 16'hFFE0;
endpackage

// File: rtl/xflag_arith.sv
module xflag_arith
  import xflag_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  flags_t            flags_i,
  output logic [DATA_W-1:0] res_o,
  output flags_t            flags_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W-1:0] sum_x, dif_x, dif, src_radd, src_rsub;
  logic [DATA_W-1:0] vv_addx, vv_subx, vv_cmp, vv_radd, vv_rsub;
  logic              cy_addx, bw_subx;

  assign sum_x    = a_i + b_i + DATA_W'(flags_i.x);
  assign dif_x    = a_i - b_i - DATA_W'(flags_i.x);
  assign dif      = a_i - b_i;
  assign src_radd = a_i - b_i;
  assign src_rsub = a_i + b_i;

  // carry/borrow test tightens to <= when extend is set
  assign cy_addx = flags_i.x ? (sum_x <= b_i) : (sum_x < b_i);
  assign bw_subx = flags_i.x ? (a_i <= b_i) : (a_i < b_i);

  assign vv_addx = (sum_x ^ a_i) & ~(a_i ^ b_i);
  assign vv_subx = (dif_x ^ a_i) & (a_i ^ b_i);
  assign vv_cmp  = (dif ^ a_i) & (a_i ^ b_i);
  assign vv_radd = (a_i ^ src_radd) & ~(src_radd ^ b_i);
  assign vv_rsub = (a_i ^ src_rsub) & (src_rsub ^ b_i);

  always_comb begin
    flags_o = flags_i;
    res_o   = '0;
    case (op_i)
      OP_ADDX: begin
        res_o     = sum_x;
        flags_o.x = cy_addx;
        flags_o.c = cy_addx;
        flags_o.n = sum_x[MSB];
        flags_o.z = flags_i.z & (sum_x == '0);
        flags_o.v = vv_addx[MSB];
      end
      OP_SUBX: begin
        res_o     = dif_x;
        flags_o.x = bw_subx;
        flags_o.c = bw_subx;
        flags_o.n = dif_x[MSB];
        flags_o.z = flags_i.z & (dif_x == '0);
        flags_o.v = vv_subx[MSB];
      end
      OP_CMP: begin
        res_o     = dif;
        flags_o.c = a_i < b_i;
        flags_o.n = dif[MSB];
        flags_o.z = dif == '0;
        flags_o.v = vv_cmp[MSB];
      end
      OP_RADD, OP_RSUB: begin
        res_o     = a_i;
        flags_o.c = flags_i.x;
        flags_o.n = a_i[MSB];
        flags_o.z = a_i == '0;
        flags_o.v = (op_i == OP_RADD) ? vv_radd[MSB] : vv_rsub[MSB];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/xflag_shift.sv
module xflag_shift
  import xflag_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 8
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [CNT_W-1:0]  shamt_i,
  input  flags_t            flags_i,
  output logic [DATA_W-1:0] res_o,
  output flags_t            flags_o
);
  localparam int unsigned MSB   = DATA_W - 1;
  localparam int unsigned MOD_W = $clog2(2 * DATA_W);

  logic [MOD_W-1:0] cnt;
  logic [DATA_W:0]  lsl_t, lsr_t, asr_t;
  logic [DATA_W-1:0] r;
  logic             c;

  assign cnt = MOD_W'(shamt_i % CNT_W'(2 * DATA_W));

  // one guard bit beyond the word holds the last bit shifted out
  assign lsl_t = {1'b0, a_i} << cnt;
  assign lsr_t = {a_i, 1'b0} >> cnt;
  assign asr_t = $signed({a_i, 1'b0}) >>> cnt;

  always_comb begin
    case (op_i)
      OP_LSL:  begin r = lsl_t[DATA_W-1:0]; c = lsl_t[DATA_W]; end
      OP_LSR:  begin r = lsr_t[DATA_W:1];   c = lsr_t[0];      end
      default: begin r = asr_t[DATA_W:1];   c = asr_t[0];      end
    endcase
  end

  always_comb begin
    flags_o   = flags_i;
    res_o     = r;
    flags_o.c = c;
    flags_o.n = r[MSB];
    flags_o.z = r == '0;
    flags_o.v = (op_i == OP_ASR) ? (r[MSB] ^ a_i[MSB]) : 1'b0;
    flags_o.x = (cnt != '0) ? c : flags_i.x;
  end
endmodule

// File: rtl/xflag_xfer.sv
module xflag_xfer
  import xflag_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] a_i,
  input  flags_t            flags_i,
  output logic [DATA_W-1:0] res_o,
  output flags_t            flags_o
);
  localparam int unsigned MSB = DATA_W - 1;
  localparam logic [DATA_W-1:0] SR_MASK  = DATA_W'(SR_KEEP);
  localparam logic [DATA_W-1:0] CCR_MASK = DATA_W'({FLAG_W{1'b1}});

  always_comb begin
    flags_o = flags_i;
    res_o   = '0;
    case (op_i)
      OP_LOGIC: begin
        res_o     = a_i;
        flags_o.n = a_i[MSB];
        flags_o.z = a_i == '0;
        flags_o.v = 1'b0;
        flags_o.c = 1'b0;
      end
      OP_PACK:  res_o = DATA_W'(flags_i);
      OP_LDCCR: begin
        res_o   = a_i & CCR_MASK;
        flags_o = flags_t'(a_i[FLAG_W-1:0]);
      end
      OP_LDSR: begin
        res_o   = a_i & SR_MASK;
        flags_o = flags_t'(a_i[FLAG_W-1:0]);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/xflag_unit.sv
module xflag_unit
  import xflag_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [CNT_W-1:0]  shamt_i,
  input  logic [4:0]        flags_i,
  output logic [DATA_W-1:0] res_o,
  output logic [4:0]        flags_o
);
  op_e               op;
  flags_t            fin;
  logic [DATA_W-1:0] ar_res, sh_res, xf_res, res_d, res_q;
  flags_t            ar_fl, sh_fl, xf_fl, fl_d, fl_q;

  assign op  = op_e'(op_i);
  assign fin = flags_t'(flags_i);

  xflag_arith #(.DATA_W(DATA_W)) i_arith (
    .op_i(op), .a_i(a_i), .b_i(b_i), .flags_i(fin),
    .res_o(ar_res), .flags_o(ar_fl)
  );

  xflag_shift #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_shift (
    .op_i(op), .a_i(a_i), .shamt_i(shamt_i), .flags_i(fin),
    .res_o(sh_res), .flags_o(sh_fl)
  );

  xflag_xfer #(.DATA_W(DATA_W)) i_xfer (
    .op_i(op), .a_i(a_i), .flags_i(fin),
    .res_o(xf_res), .flags_o(xf_fl)
  );

  always_comb begin
    case (op)
      OP_ADDX, OP_SUBX, OP_CMP, OP_RADD, OP_RSUB: begin res_d = ar_res; fl_d = ar_fl; end
      OP_LSL, OP_LSR, OP_ASR:                     begin res_d = sh_res; fl_d = sh_fl; end
      OP_LOGIC, OP_PACK, OP_LDCCR, OP_LDSR:       begin res_d = xf_res; fl_d = xf_fl; end
      default:                                    begin res_d = '0;     fl_d = fin;   end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      fl_q  <= '0;
    end else if (valid_i) begin
      res_q <= res_d;
      fl_q  <= fl_d;
    end
  end

  assign res_o   = res_q;
  assign flags_o = fl_q;

  // R1
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(res_o) && $stable(flags_o)));

  // R2
  ext_xc_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == 4'h0 || op_i == 4'h1)) |=> (flags_o[4] == flags_o[0]));

  // R4
  sticky_z_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == 4'h0 || op_i == 4'h1) && !flags_i[2]) |=> !flags_o[2]);

  // R8
  zero_cnt_keep_x_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == 4'h2 || op_i == 4'h3 || op_i == 4'h4) && (shamt_i[5:0] == 6'd0))
    |=> (flags_o[4] == $past(flags_i[4]) && !flags_o[0] && res_o == $past(a_i)));

  // R10
  logic_cv_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'h8) |=> (flags_o[1:0] == 2'b00));

  // R13
  load_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == 4'hA || op_i == 4'hB)) |=> (flags_o == $past(a_i[4:0])));
endmodule

// File: tb/test_xflag_unit.sv
`timescale 1ns/1ps
module test_xflag_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] a_i = '0, b_i = '0;
  logic [7:0]  shamt_i = '0;
  logic [4:0]  flags_i = '0;
  logic [31:0] res_o;
  logic [4:0]  flags_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  xflag_unit i_xflag_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .shamt_i(shamt_i), .flags_i(flags_i),
    .res_o(res_o), .flags_o(flags_o)
  );

  task automatic chk32(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s result act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk5(string tag, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s flags act=%b exp=%b", tag, act, exp);
    end
  endtask

  // drive on negedge, sample one negedge later (one register stage)
  task automatic run(string tag, logic [3:0] op, logic [31:0] a, logic [31:0] b,
                     logic [7:0] sh, logic [4:0] fl, logic [31:0] er, logic [4:0] ef);
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; a_i = a; b_i = b; shamt_i = sh; flags_i = fl;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk32(tag, res_o, er);
    chk5(tag, flags_o, ef);
  endtask

  task automatic t_reset;
    chk32("R1 reset", res_o, 32'h0);
    chk5("R1 reset", flags_o, 5'b00000);
  endtask

  task automatic t_addx;
    run("R2 R4 addx wrap x0",   4'h0, 32'hFFFFFFFF, 32'h1, 8'd0, 5'b00100, 32'h0, 5'b10101);
    run("R5 addx ovf x1",       4'h0, 32'h7FFFFFFF, 32'h0, 8'd0, 5'b10100, 32'h80000000, 5'b01010);
    run("R2 R4 addx eq-b x1",   4'h0, 32'hFFFFFFFF, 32'h0, 8'd0, 5'b10000, 32'h0, 5'b10001);
  endtask

  task automatic t_subx;
    run("R3 subx x1 equal",     4'h1, 32'h5, 32'h5, 8'd0, 5'b10100, 32'hFFFFFFFF, 5'b11001);
    run("R5 subx ovf",          4'h1, 32'h80000000, 32'h1, 8'd0, 5'b00100, 32'h7FFFFFFF, 5'b00010);
    run("R4 subx zero keeps z", 4'h1, 32'h3, 32'h3, 8'd0, 5'b00100, 32'h0, 5'b00100);
  endtask

  task automatic t_shift;
    run("R6 lsl 1",       4'h2, 32'h80000001, 32'h0, 8'd1,  5'b00000, 32'h2, 5'b10001);
    run("R6 lsl 32",      4'h2, 32'h00000001, 32'h0, 8'd32, 5'b00000, 32'h0, 5'b10101);
    run("R6 lsl 33",      4'h2, 32'hFFFFFFFF, 32'h0, 8'd33, 5'b10000, 32'h0, 5'b00100);
    run("R6 lsl 65 mod",  4'h2, 32'h80000001, 32'h0, 8'd65, 5'b00000, 32'h2, 5'b10001);
    run("R7 lsr 1",       4'h3, 32'h00000003, 32'h0, 8'd1,  5'b00000, 32'h1, 5'b10001);
    run("R7 asr 4",       4'h4, 32'h80000000, 32'h0, 8'd4,  5'b10000, 32'hF8000000, 5'b01000);
    run("R7 asr 40",      4'h4, 32'h80000000, 32'h0, 8'd40, 5'b00000, 32'hFFFFFFFF, 5'b11001);
    run("R8 lsr 0",       4'h3, 32'h12345678, 32'h0, 8'd0,  5'b10011, 32'h12345678, 5'b10000);
    run("R8 lsl 64",      4'h2, 32'h00000001, 32'h0, 8'd64, 5'b10000, 32'h1, 5'b10000);
  endtask

  task automatic t_cmp_logic;
    run("R9 cmp lt",      4'h5, 32'h1, 32'h2, 8'd0, 5'b10000, 32'hFFFFFFFF, 5'b11001);
    run("R9 cmp ovf",     4'h5, 32'h80000000, 32'h1, 8'd0, 5'b00000, 32'h7FFFFFFF, 5'b00010);
    run("R9 cmp eq",      4'h5, 32'h9, 32'h9, 8'd0, 5'b00000, 32'h0, 5'b00100);
    run("R10 logic neg",  4'h8, 32'h80000000, 32'h0, 8'd0, 5'b00011, 32'h80000000, 5'b01000);
    run("R10 logic zero", 4'h8, 32'h0, 32'h0, 8'd0, 5'b10011, 32'h0, 5'b10100);
  endtask

  task automatic t_rebuild;
    run("R11 radd zero",  4'h6, 32'h0, 32'h1, 8'd0, 5'b10000, 32'h0, 5'b10101);
    run("R11 radd ovf",   4'h6, 32'h80000000, 32'h1, 8'd0, 5'b00000, 32'h80000000, 5'b01010);
    run("R11 rsub ovf",   4'h7, 32'h7FFFFFFF, 32'h1, 8'd0, 5'b10000, 32'h7FFFFFFF, 5'b10011);
  endtask

  task automatic t_xfer;
    run("R12 pack",       4'h9, 32'hDEADBEEF, 32'h0, 8'd0, 5'b10110, 32'h16, 5'b10110);
    run("R13 load ccr",   4'hA, 32'hABCDEF19, 32'h0, 8'd0, 5'b00000, 32'h19, 5'b11001);
    run("R13 status wr",  4'hB, 32'h1234FFF3, 32'h0, 8'd0, 5'b00000, 32'h0000FFE0, 5'b10011);
  endtask

  task automatic t_hold;
    run("R1 load",        4'h8, 32'h00000055, 32'h0, 8'd0, 5'b00000, 32'h55, 5'b00000);
    @(negedge clk_i);
    valid_i = 1'b0; op_i = 4'h0; a_i = 32'h1; b_i = 32'h1; flags_i = 5'b11111;
    @(negedge clk_i);
    @(negedge clk_i);
    chk32("R1 hold", res_o, 32'h55);
    chk5("R1 hold", flags_o, 5'b00000);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL R1 watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_addx();
    t_subx();
    t_shift();
    t_cmp_logic();
    t_rebuild();
    t_xfer();
    t_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule